// File: doc/BRIEF.md
# Branch Condition Evaluator

This block decides whether a conditional control transfer or conditional move goes ahead. It holds a registered copy of the four status flags: zero (Z), carry (C), negative (N) and signed overflow (V). When the instruction being executed asks for a condition, it compares a 4-bit condition code against those flags and drives a combinational taken result.

The flags have a lifetime of one instruction. A flag write makes them valid. The next retiring instruction that does not write the flags again ends that lifetime. A call or return strobe ends it at once. If an instruction consumes a flag-dependent condition while the flags are not valid, or presents one of the two reserved codes, the block raises an error and forces the result to not-taken. Producing the flags is left to the execution units.

Top module: `branch_cond_eval`

## Requirements
- R1: After reset the stored flags are invalid. Evaluating any flag-dependent code before the first flag write gives err_o=1 and taken_o=0.
- R2: While the flags are valid, taken_o follows the code. The low three bits select the base test: 000 true, 001 Z, 010 C, 011 Z|C, 100 N, 110 N|Z, 111 V. Bit 3 set inverts the base test. The flags used are those captured at the most recent flag write, and they do not change between writes.
- R3: Code 0000 is always taken and code 1000 is never taken. Neither one raises err_o, even while the flags are invalid.
- R4: Codes 0101 and 1101 are reserved. Evaluating either one gives err_o=1 and taken_o=0, whether the flags are valid or not.
- R5: A flag write with no call/return strobe makes the flags valid from the next cycle. They stay valid over cycles with no retire strobe.
- R6: A retire strobe without a flag write in the same cycle makes the flags invalid from the next cycle.
- R7: A retire strobe together with a flag write keeps the flags valid and replaces them with the new values.
- R8: A call/return strobe makes the flags invalid from the next cycle, even when a flag write happens in the same cycle.
- R9: An evaluation while err_o is high never reports taken.
- R10: With the evaluate strobe low, both taken_o and err_o are low, whatever the code.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| flag_we_i | input | 1 | Current instruction writes all flags |
| flag_z_i | input | 1 | Zero flag to capture |
| flag_c_i | input | 1 | Carry flag to capture |
| flag_n_i | input | 1 | Negative flag to capture |
| flag_v_i | input | 1 | Signed overflow flag to capture |
| retire_i | input | 1 | An instruction retires this cycle |
| xfer_i | input | 1 | Call or return executes this cycle |
| eval_i | input | 1 | Current instruction consumes a condition |
| cond_i | input | 4 | Condition code |
| taken_o | output | 1 | Condition true and usable |
| err_o | output | 1 | Invalid flag use or reserved code |

## Verification
A stale valid bit would show up as a missing err_o. It appears on the first flag-dependent evaluation in the cycle after the retire or call/return that should have ended the flag lifetime. A flag register that is wrong or updates at the wrong time gives a wrong taken_o on the first code that tests that flag. Because of this, the bench sweeps all sixteen codes against all sixteen flag patterns and samples the outputs in the same cycle as each evaluation.

// File: rtl/branch_cond_pkg.sv
package branch_cond_pkg;
  localparam int unsigned CODE_W = 4;
  localparam int unsigned SEL_W  = CODE_W - 1;

  typedef struct packed {
    logic z;
    logic c;
    logic n;
    logic v;
  } flags_t;

  typedef enum logic [SEL_W-1:0] {
    SEL_TRUE = 3'b000,
    SEL_Z    = 3'b001,
    SEL_C    = 3'b010,
    SEL_ZC   = 3'b011,
    SEL_N    = 3'b100,
    SEL_RSVD = 3'b101,
    SEL_NZ   = 3'b110,
    SEL_V    = 3'b111
  } cond_sel_e;
endpackage

// File: rtl/flag_store.sv
module flag_store
  import branch_cond_pkg::*;
(
  input  logic   clk_i,
  input  logic   rst_ni,
  input  logic   flag_we_i,
  input  flags_t flags_i,
  input  logic   retire_i,
  input  logic   xfer_i,
  output flags_t flags_o,
  output logic   valid_o
);
  flags_t flags_q;
  logic   valid_q;
  logic   valid_d;

  // call/return dominates a write; a write dominates the retire clear
  always_comb begin
    valid_d = valid_q;
    if (xfer_i)         valid_d = 1'b0;
    else if (flag_we_i) valid_d = 1'b1;
    else if (retire_i)  valid_d = 1'b0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      flags_q <= '0;
      valid_q <= 1'b0;
    end else begin
      valid_q <= valid_d;
      if (flag_we_i) flags_q <= flags_i;
    end
  end

  assign flags_o = flags_q;
  assign valid_o = valid_q;

  a_r5_write_sets_valid: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flag_we_i && !xfer_i |=> valid_q);
  a_r6_retire_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    retire_i && !flag_we_i && !xfer_i |=> !valid_q);
  a_r8_xfer_invalidates: assert property (@(posedge clk_i) disable iff (!rst_ni)
    xfer_i |=> !valid_q);
  a_r2_flags_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !flag_we_i |=> $stable(flags_q));
endmodule

// File: rtl/cond_decode.sv
module cond_decode
  import branch_cond_pkg::*;
(
  input  logic [CODE_W-1:0] cond_i,
  input  flags_t            flags_i,
  output logic              hit_o,
  output logic              rsvd_o,
  output logic              uses_flags_o
);
  cond_sel_e sel;
  logic      base;

  assign sel = cond_sel_e'(cond_i[SEL_W-1:0]);

  always_comb begin
    unique case (sel)
      SEL_TRUE: base = 1'b1;
      SEL_Z:    base = flags_i.z;
      SEL_C:    base = flags_i.c;
      SEL_ZC:   base = flags_i.z | flags_i.c;
      SEL_N:    base = flags_i.n;
      SEL_NZ:   base = flags_i.n | flags_i.z;
      SEL_V:    base = flags_i.v;
      default:  base = 1'b0;
    endcase
  end

  // top bit is the polarity of the base test
  assign hit_o        = base ^ cond_i[CODE_W-1];
  assign rsvd_o       = (sel == SEL_RSVD);
  assign uses_flags_o = (sel != SEL_TRUE) && (sel != SEL_RSVD);
endmodule

// File: rtl/branch_cond_eval.sv
module branch_cond_eval
  import branch_cond_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              flag_we_i,
  input  logic              flag_z_i,
  input  logic              flag_c_i,
  input  logic              flag_n_i,
  input  logic              flag_v_i,
  input  logic              retire_i,
  input  logic              xfer_i,
  input  logic              eval_i,
  input  logic [CODE_W-1:0] cond_i,
  output logic              taken_o,
  output logic              err_o
);
  flags_t new_flags;
  flags_t cur_flags;
  logic   flags_valid;
  logic   hit;
  logic   rsvd;
  logic   uses_flags;
  logic   bad_use;

  assign new_flags = '{z: flag_z_i, c: flag_c_i, n: flag_n_i, v: flag_v_i};

  flag_store u_store (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .flag_we_i (flag_we_i),
    .flags_i   (new_flags),
    .retire_i  (retire_i),
    .xfer_i    (xfer_i),
    .flags_o   (cur_flags),
    .valid_o   (flags_valid)
  );

  cond_decode u_decode (
    .cond_i       (cond_i),
    .flags_i      (cur_flags),
    .hit_o        (hit),
    .rsvd_o       (rsvd),
    .uses_flags_o (uses_flags)
  );

  assign bad_use = rsvd | (uses_flags & ~flags_valid);
  assign err_o   = eval_i & bad_use;
  assign taken_o = eval_i & ~bad_use & hit;

  a_r9_err_not_taken: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> !taken_o);
  a_r10_idle_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !eval_i |-> !taken_o && !err_o);
  a_r4_reserved_err: assert property (@(posedge clk_i) disable iff (!rst_ni)
    eval_i && cond_i[2:0] == 3'b101 |-> err_o);
  a_r3_fixed_codes: assert property (@(posedge clk_i) disable iff (!rst_ni)
    eval_i && cond_i[2:0] == 3'b000 |-> !err_o && (taken_o == !cond_i[3]));
  a_r8_xfer_blocks_use: assert property (@(posedge clk_i) disable iff (!rst_ni)
    xfer_i ##1 (eval_i && cond_i == 4'b0001) |-> err_o);
endmodule

// File: tb/branch_cond_eval_tb_top.sv
`timescale 1ns/1ps
module branch_cond_eval_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       flag_we = 1'b0, fz = 1'b0, fc = 1'b0, fn = 1'b0, fv = 1'b0;
  logic       retire = 1'b0, xfer = 1'b0, eval = 1'b0;
  logic [3:0] cond = 4'd0;
  logic       taken, err;
  int         n_checks = 0;
  int         n_errs = 0;
  bit         done = 1'b0;

  always #2.5 clk = ~clk;

  branch_cond_eval dut_i (
    .clk_i(clk), .rst_ni(rst_n), .flag_we_i(flag_we),
    .flag_z_i(fz), .flag_c_i(fc), .flag_n_i(fn), .flag_v_i(fv),
    .retire_i(retire), .xfer_i(xfer), .eval_i(eval), .cond_i(cond),
    .taken_o(taken), .err_o(err)
  );

  // flags packed as {z,c,n,v}
  function automatic bit model_cond(input logic [3:0] c, input logic [3:0] f);
    bit z, cy, n, v, r;
    z = f[3]; cy = f[2]; n = f[1]; v = f[0];
    case (c)
      4'b0000: r = 1;        4'b1000: r = 0;
      4'b0001: r = z;        4'b1001: r = !z;
      4'b0010: r = cy;       4'b1010: r = !cy;
      4'b0011: r = z || cy;  4'b1011: r = !z && !cy;
      4'b0100: r = n;        4'b1100: r = !n;
      4'b0110: r = n || z;   4'b1110: r = !n && !z;
      4'b0111: r = v;        4'b1111: r = !v;
      default: r = 0;
    endcase
    return r;
  endfunction

  task automatic drive(input bit we, input logic [3:0] f, input bit ret,
                       input bit xf, input bit ev, input logic [3:0] c);
    @(negedge clk);
    flag_we = we; {fz, fc, fn, fv} = f; retire = ret; xfer = xf; eval = ev; cond = c;
    #1;
  endtask

  task automatic check(input string req, input bit exp_t, input bit exp_e);
    n_checks++;
    if (taken !== exp_t || err !== exp_e) begin
      n_errs++;
      $display("FAIL %s: cond=%b taken/err=%b%b expected %b%b", req, cond, taken, err, exp_t, exp_e);
    end
  endtask

  task automatic t_reset;
    drive(0, 4'h0, 0, 0, 0, 4'b0001);
    check("R10 idle after reset", 0, 0);
    drive(0, 4'h0, 0, 0, 1, 4'b0001);
    check("R1 invalid after reset", 0, 1);
    drive(0, 4'h0, 0, 0, 1, 4'b1100);
    check("R1 invalid after reset", 0, 1);
  endtask

  task automatic t_fixed_codes;
    drive(0, 4'h0, 0, 0, 1, 4'b0000);
    check("R3 always while invalid", 1, 0);
    drive(0, 4'h0, 0, 0, 1, 4'b1000);
    check("R3 never while invalid", 0, 0);
    drive(0, 4'h0, 0, 0, 1, 4'b0101);
    check("R4 reserved while invalid", 0, 1);
    drive(0, 4'h0, 0, 0, 1, 4'b1101);
    check("R4 reserved while invalid", 0, 1);
  endtask

  task automatic t_sweep;
    for (int f = 0; f < 16; f++) begin
      drive(1, 4'(f), 0, 0, 0, 4'h0);
      for (int c = 0; c < 16; c++) begin
        bit rs;
        rs = (c[2:0] == 3'b101);
        drive(0, ~4'(f), 0, 0, 1, 4'(c));
        check(rs ? "R4 reserved valid" : "R2 code sweep", rs ? 0 : model_cond(4'(c), 4'(f)), rs);
      end
      drive(0, 4'h0, 1, 0, 0, 4'h0);
    end
  endtask

  task automatic t_lifetime;
    drive(1, 4'b1000, 1, 0, 0, 4'h0);
    drive(0, 4'b0000, 1, 0, 1, 4'b0001);
    check("R5 valid for next instruction", 1, 0);
    drive(0, 4'b0000, 0, 0, 1, 4'b0001);
    check("R6 retire clears", 0, 1);
    drive(0, 4'b0000, 0, 0, 1, 4'b1001);
    check("R9 invalid not taken", 0, 1);
  endtask

  task automatic t_chain;
    drive(1, 4'b0100, 1, 0, 0, 4'h0);
    drive(1, 4'b0010, 1, 0, 1, 4'b0010);
    check("R7 first flags", 1, 0);
    drive(0, 4'b0000, 1, 0, 1, 4'b0100);
    check("R7 rewritten flags", 1, 0);
    drive(0, 4'b0000, 0, 0, 1, 4'b0010);
    check("R6 after chain", 0, 1);
  endtask

  task automatic t_xfer;
    drive(1, 4'b1000, 0, 0, 0, 4'h0);
    drive(0, 4'b0000, 0, 1, 1, 4'b0001);
    check("R5 valid before xfer", 1, 0);
    drive(0, 4'b0000, 0, 0, 1, 4'b0001);
    check("R8 xfer invalidates", 0, 1);
    drive(1, 4'b1000, 1, 1, 0, 4'h0);
    drive(0, 4'b0000, 0, 0, 1, 4'b0001);
    check("R8 xfer beats write", 0, 1);
    drive(0, 4'b0000, 0, 0, 1, 4'b0000);
    check("R3 always after xfer", 1, 0);
  endtask

  task automatic t_idle;
    drive(1, 4'b1111, 0, 0, 0, 4'h0);
    drive(0, 4'b0000, 0, 0, 0, 4'b0001);
    check("R10 idle valid", 0, 0);
    drive(0, 4'b0000, 0, 0, 0, 4'b0101);
    check("R10 idle reserved", 0, 0);
    drive(0, 4'b0000, 0, 0, 1, 4'b0111);
    check("R5 held without retire", 1, 0);
  endtask

  initial begin
    #1;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    t_reset();
    t_fixed_codes();
    t_sweep();
    t_lifetime();
    t_chain();
    t_xfer();
    t_idle();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        n_checks++;
        n_errs++;
        $display("FAIL watchdog: run did not finish, expected completion");
      end
    join_any
    $display("Result: errors=%0d of %0d checks", n_errs, n_checks);
    $finish;
  end
endmodule